// File: doc/BRIEF.md
# Floppy Controller Host Command Port

This block is the register side of a legacy floppy disk controller as seen by the host. It has three things the host can touch. A control register selects the drive, turns the motors on, opens the interrupt gate and holds the controller in reset. A status byte tells the host when it may move a byte and in which direction. A data port carries command, parameter and result bytes. A phase machine walks each command through opcode acceptance, parameter collection, an optional execution delay, result delivery and a short busy tail.

The commands handled are version, configure, specify, sense interrupt status and recalibrate. Any other opcode is rejected with an invalid-command result. Execution is modelled only as a programmable delay. There are no media, no seek timing, no data transfers and no DMA. When reset is released, every drive is flagged as having a pending interrupt. A host driver must therefore issue one sense-interrupt command per drive before the interrupt line settles. Any byte offered at the wrong moment is dropped, and a sticky error flag records it.

Top module: `fdc_host_port`

## Requirements
- R1: After the synchronous reset `rst`, the control register reads 0x00, the controller is held in reset, `status` reads 0x00, `irq` is low and `access_err` is low.
- R2: The control register is loaded by `ctl_wr` and reads back whole on `ctl_rdata`. Its fields are:
  - bits 1:0: `drive_sel`
  - bit 2: must be 1 to run the controller (0 holds it in reset)
  - bit 3: interrupt gate
  - bit 4: `motor_on[0]`
  - bit 5: `motor_on[1]`
- R3: Clearing bit 2 forces `status` to 0x00 and aborts any command. Changing bit 2 from 0 to 1 marks all four drives as interrupt-pending, and the phase machine then goes idle with `status` reading 0x80. While bit 3 is set, `irq` is high whenever any drive is pending.
- R4: Status bit 7 means ready, bit 6 means controller-to-host, bit 5 means execution in progress and bit 4 means command busy. After every accepted data-port write, bit 7 reads 0 in the next cycle. While parameter bytes are still awaited, `status` reads 0x90.
- R5: Configure (0x13, three parameters) and specify (0x03, two parameters) return no result. After the last parameter, ready comes back first and `status` reads 0x90 for a few cycles, then busy clears and `status` reads 0x80.
- R6: Version (0x10) takes no parameters and returns one byte, 0x90. While it is offered, `status` reads 0xD0.
- R7: Sense interrupt status (0x08), issued while a drive is pending, returns two bytes. The first byte is 0xC0 OR the drive number for a drive pending from reset release, and 0x20 OR the drive number for a drive pending from a finished recalibrate. The second byte is 0x00. The lowest-numbered pending drive is served first and its pending flag is cleared. `irq` falls once no drive is pending.
- R8: Sense interrupt status issued with no drive pending returns a single byte, 0x80.
- R9: Recalibrate (0x07) takes one parameter whose bits 1:0 name the drive. It then shows `status` 0x30 for the execution delay and returns to 0x80 with that drive pending, so the next sense returns 0x20 OR the drive number.
- R10: Any other opcode returns a single result byte, 0x80, and the machine then returns to idle.
- R11: A data-port write is ignored and sets the sticky `access_err` in three cases:
  - outside idle and parameter collection (including the busy tail);
  - while status bit 7 is 0;
  - while the controller is held in reset.

  A data-port read outside result delivery is likewise ignored: `dat_rdata` stays unchanged and `access_err` is set.
- R12: Command busy (status bit 4) never falls while ready is low, unless `status` drops to 0x00 because reset is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Command or parameter byte |
| dat_rd | input | 1 | Data-port read strobe |
| dat_rdata | output | 8 | Last result byte read |
| status | output | 8 | Handshake status byte |
| irq | output | 1 | Interrupt request, gated by control bit 3 |
| drive_sel | output | 2 | Selected drive |
| motor_on | output | 2 | Motor enables for drives 0 and 1 |
| access_err | output | 1 | Sticky flag for ignored accesses |

## Verification
The assertions assume that each strobe lasts exactly one clock and that `dat_wr` and `dat_rd` are never raised in the same cycle. The pending-count property also assumes that a sense command is only acted on when some drive is pending, which the phase machine guarantees. The bench follows the handshake a real driver uses. It polls `status` until ready and direction allow the next move, and only then pulses a single strobe. The two deliberate protocol violations are confined to one scenario: a read while idle and a write while a byte is still being taken.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [2:0] {
    PH_RST, PH_IDLE, PH_ACC, PH_PARM, PH_TAIL, PH_EXEC, PH_RES, PH_DRAIN
  } phase_t;

  localparam logic [7:0] OP_VERSION = 8'h10;
  localparam logic [7:0] OP_CONFIG  = 8'h13;
  localparam logic [7:0] OP_SPECIFY = 8'h03;
  localparam logic [7:0] OP_SENSE   = 8'h08;
  localparam logic [7:0] OP_RECAL   = 8'h07;

  localparam logic [7:0] RES_VERSION = 8'h90;
  localparam logic [7:0] RES_INVALID = 8'h80;
  localparam logic [7:0] SNS_RESET   = 8'hC0;
  localparam logic [7:0] SNS_SEEKEND = 8'h20;

  localparam logic [7:0] ST_RDY  = 8'h80;
  localparam logic [7:0] ST_DIR  = 8'h40;
  localparam logic [7:0] ST_EXEC = 8'h20;
  localparam logic [7:0] ST_BUSY = 8'h10;

  function automatic logic [7:0] phase_status(phase_t p);
    case (p)
      PH_IDLE:  phase_status = ST_RDY;
      PH_ACC:   phase_status = ST_BUSY;
      PH_PARM:  phase_status = ST_RDY | ST_BUSY;
      PH_TAIL:  phase_status = ST_RDY | ST_BUSY;
      PH_EXEC:  phase_status = ST_EXEC | ST_BUSY;
      PH_RES:   phase_status = ST_RDY | ST_DIR | ST_BUSY;
      PH_DRAIN: phase_status = ST_DIR | ST_BUSY;
      default:  phase_status = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fdc_ctl_reg.sv
module fdc_ctl_reg #(
  parameter int DRV_W   = 2,
  parameter int MOTOR_N = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr_i,
  input  logic [7:0]         ctl_wdata_i,
  output logic [7:0]         dor_o,
  output logic               in_reset_o,
  output logic               gate_o,
  output logic               rel_o,
  output logic [DRV_W-1:0]   drive_sel_o,
  output logic [MOTOR_N-1:0] motor_o
);
  localparam int RUN_BIT   = 2;
  localparam int GATE_BIT  = 3;
  localparam int MOTOR_LSB = 4;

  logic [7:0] dor_q;
  logic       rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dor_q <= 8'h00;
      rel_q <= 1'b0;
    end else begin
      rel_q <= ctl_wr_i && ctl_wdata_i[RUN_BIT] && !dor_q[RUN_BIT];
      if (ctl_wr_i) dor_q <= ctl_wdata_i;
    end
  end

  assign dor_o       = dor_q;
  assign in_reset_o  = !dor_q[RUN_BIT];
  assign gate_o      = dor_q[GATE_BIT];
  assign rel_o       = rel_q;
  assign drive_sel_o = dor_q[DRV_W-1:0];

  for (genvar m = 0; m < MOTOR_N; m++) begin : g_motor
    assign motor_o[m] = dor_q[MOTOR_LSB+m];
  end

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_i |=> dor_q == $past(ctl_wdata_i));
endmodule

// File: rtl/fdc_int_track.sv
module fdc_int_track #(
  parameter int DRV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_i,
  input  logic             rel_i,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [DRV_W-1:0] set_drv_i,
  output logic             pend_any_o,
  output logic [DRV_W-1:0] pend_drv_o,
  output logic             pend_seek_o,
  output logic             irq_o
);
  localparam int NUM_DRV = 1 << DRV_W;

  logic [NUM_DRV-1:0] pend_q, seek_q;
  logic [DRV_W-1:0]   first;
  logic               irq_q;

  always_comb begin
    first = '0;
    for (int i = NUM_DRV - 1; i >= 0; i--)
      if (pend_q[i]) first = DRV_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      seek_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (rel_i) begin
        pend_q <= '1;
        seek_q <= '0;
      end else begin
        if (clr_i) pend_q[first] <= 1'b0;
        if (set_i) begin
          pend_q[set_drv_i] <= 1'b1;
          seek_q[set_drv_i] <= 1'b1;
        end
      end
      irq_q <= gate_i && (|pend_q);
    end
  end

  assign pend_any_o  = |pend_q;
  assign pend_drv_o  = first;
  assign pend_seek_o = seek_q[first];
  assign irq_o       = irq_q;

  // R3
  rel_all_pend_chk: assert property (@(posedge clk) disable iff (rst)
    rel_i |=> pend_q == '1);
  // R7
  sense_clears_one_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !rel_i) |=> $countones(pend_q) == $past($countones(pend_q)) - 1);
endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
  import fdc_pkg::*;
#(
  parameter int PROC_CYC = 2,
  parameter int TAIL_CYC = 3,
  parameter int EXEC_CYC = 12,
  parameter int DRV_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_reset_i,
  input  logic             dat_wr_i,
  input  logic [7:0]       dat_wdata_i,
  input  logic             dat_rd_i,
  input  logic             pend_any_i,
  input  logic [DRV_W-1:0] pend_drv_i,
  input  logic             pend_seek_i,
  output logic [7:0]       status_o,
  output logic [7:0]       rdata_o,
  output logic             err_o,
  output logic             clr_req_o,
  output logic             set_req_o,
  output logic [DRV_W-1:0] set_drv_o
);
  localparam int MAX_A = (PROC_CYC > TAIL_CYC) ? PROC_CYC : TAIL_CYC;
  localparam int MAX_C = (MAX_A > EXEC_CYC) ? MAX_A : EXEC_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  phase_t           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       op_q, op_d, r0_q, r0_d, r1_q, r1_d, rdata_q, rdata_d, status_q;
  logic [1:0]       par_q, par_d, rl_q, rl_d;
  logic [DRV_W-1:0] drv_q, drv_d;
  logic             err_q, err_d, wr_ok, rd_ok;

  assign wr_ok = (state_q == PH_IDLE) || (state_q == PH_PARM);
  assign rd_ok = (state_q == PH_RES);

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; op_d = op_q; par_d = par_q;
    r0_d = r0_q; r1_d = r1_q; rl_d = rl_q; drv_d = drv_q;
    rdata_d = rdata_q; err_d = err_q;
    clr_req_o = 1'b0; set_req_o = 1'b0;
    if ((dat_wr_i && !wr_ok) || (dat_rd_i && !rd_ok)) err_d = 1'b1;
    if (in_reset_i) begin
      state_d = PH_RST; par_d = '0; rl_d = '0;
    end else begin
      case (state_q)
        PH_RST: state_d = PH_IDLE;
        PH_IDLE: if (dat_wr_i) begin
          op_d = dat_wdata_i; state_d = PH_ACC; cnt_d = CNT_W'(PROC_CYC - 1);
          par_d = 2'd0; rl_d = 2'd1; r0_d = RES_INVALID; r1_d = 8'h00;
          case (dat_wdata_i)
            OP_VERSION: r0_d = RES_VERSION;
            OP_CONFIG:  begin par_d = 2'd3; rl_d = 2'd0; end
            OP_SPECIFY: begin par_d = 2'd2; rl_d = 2'd0; end
            OP_RECAL:   begin par_d = 2'd1; rl_d = 2'd0; end
            OP_SENSE: if (pend_any_i) begin
              clr_req_o = 1'b1; rl_d = 2'd2;
              r0_d = {{(8-DRV_W){1'b0}}, pend_drv_i} | (pend_seek_i ? SNS_SEEKEND : SNS_RESET);
            end
            default: ;
          endcase
        end
        PH_PARM: if (dat_wr_i) begin
          par_d = par_q - 2'd1; state_d = PH_ACC; cnt_d = CNT_W'(PROC_CYC - 1);
          if (op_q == OP_RECAL) drv_d = dat_wdata_i[DRV_W-1:0];
        end
        PH_ACC: if (cnt_q == '0) begin
          if (par_q != 2'd0) state_d = PH_PARM;
          else if (rl_q != 2'd0) state_d = PH_RES;
          else if (op_q == OP_RECAL) begin state_d = PH_EXEC; cnt_d = CNT_W'(EXEC_CYC - 1); end
          else begin state_d = PH_TAIL; cnt_d = CNT_W'(TAIL_CYC - 1); end
        end else cnt_d = cnt_q - 1'b1;
        PH_TAIL: if (cnt_q == '0) state_d = PH_IDLE; else cnt_d = cnt_q - 1'b1;
        PH_EXEC: if (cnt_q == '0) begin
          set_req_o = 1'b1; state_d = PH_IDLE;
        end else cnt_d = cnt_q - 1'b1;
        PH_RES: if (dat_rd_i) begin
          rdata_d = r0_q; r0_d = r1_q; rl_d = rl_q - 2'd1;
          state_d = PH_DRAIN; cnt_d = CNT_W'(PROC_CYC - 1);
        end
        PH_DRAIN: if (cnt_q == '0) state_d = (rl_q != 2'd0) ? PH_RES : PH_IDLE;
                  else cnt_d = cnt_q - 1'b1;
        default: state_d = PH_RST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_RST; cnt_q <= '0; op_q <= 8'h00; par_q <= '0; rl_q <= '0;
      r0_q <= 8'h00; r1_q <= 8'h00; drv_q <= '0; rdata_q <= 8'h00;
      err_q <= 1'b0; status_q <= 8'h00;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; op_q <= op_d; par_q <= par_d; rl_q <= rl_d;
      r0_q <= r0_d; r1_q <= r1_d; drv_q <= drv_d; rdata_q <= rdata_d;
      err_q <= err_d; status_q <= phase_status(state_d);
    end
  end

  assign status_o  = status_q;
  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign set_drv_o = drv_q;

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && wr_ok) |=> !status_q[7]);
  // R11
  bad_wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !wr_ok) |=> err_q);
  // R11
  bad_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_rd_i && !rd_ok) |=> $stable(rdata_q) && err_q);
  // R12
  busy_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[4]) |-> (status_q[7] || status_q == 8'h00));
endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port #(
  parameter int PROC_CYC = 2,
  parameter int TAIL_CYC = 3,
  parameter int EXEC_CYC = 12,
  parameter int DRV_W    = 2,
  parameter int MOTOR_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr,
  input  logic [7:0]         ctl_wdata,
  output logic [7:0]         ctl_rdata,
  input  logic               dat_wr,
  input  logic [7:0]         dat_wdata,
  input  logic               dat_rd,
  output logic [7:0]         dat_rdata,
  output logic [7:0]         status,
  output logic               irq,
  output logic [DRV_W-1:0]   drive_sel,
  output logic [MOTOR_N-1:0] motor_on,
  output logic               access_err
);
  logic             in_reset, gate, rel, clr_req, set_req, pend_any, pend_seek;
  logic [DRV_W-1:0] pend_drv, set_drv;

  fdc_ctl_reg #(.DRV_W(DRV_W), .MOTOR_N(MOTOR_N)) u_ctl (
    .clk(clk), .rst(rst), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .dor_o(ctl_rdata), .in_reset_o(in_reset), .gate_o(gate), .rel_o(rel),
    .drive_sel_o(drive_sel), .motor_o(motor_on)
  );

  fdc_int_track #(.DRV_W(DRV_W)) u_int (
    .clk(clk), .rst(rst), .gate_i(gate), .rel_i(rel), .clr_i(clr_req),
    .set_i(set_req), .set_drv_i(set_drv), .pend_any_o(pend_any),
    .pend_drv_o(pend_drv), .pend_seek_o(pend_seek), .irq_o(irq)
  );

  fdc_phase_fsm #(.PROC_CYC(PROC_CYC), .TAIL_CYC(TAIL_CYC), .EXEC_CYC(EXEC_CYC),
                  .DRV_W(DRV_W)) u_fsm (
    .clk(clk), .rst(rst), .in_reset_i(in_reset), .dat_wr_i(dat_wr),
    .dat_wdata_i(dat_wdata), .dat_rd_i(dat_rd), .pend_any_i(pend_any),
    .pend_drv_i(pend_drv), .pend_seek_i(pend_seek), .status_o(status),
    .rdata_o(dat_rdata), .err_o(access_err), .clr_req_o(clr_req),
    .set_req_o(set_req), .set_drv_o(set_drv)
  );
endmodule

// File: tb/tb_fdc_host_port.sv
module tb_fdc_host_port;
  logic       clk = 1'b0, rst = 1'b1;
  logic       ctl_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0] ctl_wdata = 8'h00, dat_wdata = 8'h00;
  logic [7:0] ctl_rdata, dat_rdata, status;
  logic       irq, access_err;
  logic [1:0] drive_sel, motor_on;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  fdc_host_port dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .status(status), .irq(irq), .drive_sel(drive_sel), .motor_on(motor_on),
    .access_err(access_err)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_st(logic [7:0] mask, logic [7:0] val);
    int n = 0;
    while (((status & mask) != val) && n < 300) begin tick(); n++; end
    if (n >= 300) chk("R4 status wait", status & mask, val);
  endtask

  task automatic ctl(logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1; tick(); ctl_wr = 1'b0;
  endtask

  task automatic put(logic [7:0] b, bit opcode);
    if (opcode) wait_st(8'hFF, 8'h80); else wait_st(8'hC0, 8'h80);
    dat_wdata = b; dat_wr = 1'b1; tick(); dat_wr = 1'b0;
    chk("R4 ready low after write", {7'b0, status[7]}, 8'h00);
  endtask

  task automatic get(output logic [7:0] b);
    wait_st(8'hC0, 8'hC0);
    chk("R6 status while offering", status, 8'hD0);
    dat_rd = 1'b1; tick(); dat_rd = 1'b0; b = dat_rdata;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    chk("R1 status", status, 8'h00);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 err", {7'b0, access_err}, 8'h00);
  endtask

  task automatic t_release();
    ctl(8'h1C); tick(); tick();
    chk("R3 irq after release", {7'b0, irq}, 8'h01);
    chk("R3 idle status", status, 8'h80);
    chk("R2 readback", ctl_rdata, 8'h1C);
    chk("R2 motor", {6'b0, motor_on}, 8'h01);
    chk("R2 drive", {6'b0, drive_sel}, 8'h00);
  endtask

  task automatic t_sense_after_reset();
    logic [7:0] b;
    for (int d = 0; d < 4; d++) begin
      put(8'h08, 1'b1);
      get(b); chk("R7 first byte", b, 8'hC0 | 8'(d));
      get(b); chk("R7 second byte", b, 8'h00);
    end
    wait_st(8'hFF, 8'h80); tick(); tick();
    chk("R7 irq low after four", {7'b0, irq}, 8'h00);
    put(8'h08, 1'b1);
    get(b); chk("R8 no pending", b, 8'h80);
    wait_st(8'h80, 8'h80);
    chk("R8 single byte", status, 8'h80);
  endtask

  task automatic t_version();
    logic [7:0] b;
    put(8'h10, 1'b1);
    get(b); chk("R6 version byte", b, 8'h90);
    wait_st(8'h80, 8'h80);
    chk("R6 back to idle", status, 8'h80);
  endtask

  task automatic t_noresult(logic [7:0] op, int np, string tag);
    put(op, 1'b1);
    wait_st(8'h80, 8'h80);
    chk("R4 awaiting params", status, 8'h90);
    for (int i = 0; i < np; i++) put(8'h40 + 8'(i), 1'b0);
    wait_st(8'h80, 8'h80);
    chk(tag, status, 8'h90);
    wait_st(8'hFF, 8'h80);
    chk(tag, status, 8'h80);
  endtask

  task automatic t_recal();
    logic [7:0] b;
    put(8'h07, 1'b1); put(8'h02, 1'b0);
    wait_st(8'h20, 8'h20);
    chk("R9 exec status", status, 8'h30);
    wait_st(8'hFF, 8'h80); tick(); tick();
    chk("R9 irq", {7'b0, irq}, 8'h01);
    put(8'h08, 1'b1);
    get(b); chk("R9 seek end", b, 8'h22);
    get(b); chk("R9 second", b, 8'h00);
    wait_st(8'hFF, 8'h80); tick();
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_unknown();
    logic [7:0] b;
    put(8'hFF, 1'b1);
    get(b); chk("R10 invalid byte", b, 8'h80);
    wait_st(8'h80, 8'h80);
    chk("R10 idle", status, 8'h80);
  endtask

  task automatic t_bad_access();
    logic [7:0] b, prev;
    chk("R11 err clear", {7'b0, access_err}, 8'h00);
    prev = dat_rdata;
    dat_rd = 1'b1; tick(); dat_rd = 1'b0;
    chk("R11 rdata held", dat_rdata, prev);
    chk("R11 err set", {7'b0, access_err}, 8'h01);
    put(8'h10, 1'b1);
    dat_wdata = 8'h13; dat_wr = 1'b1; tick(); dat_wr = 1'b0;
    get(b); chk("R11 junk ignored", b, 8'h90);
    wait_st(8'h80, 8'h80);
    chk("R11 single result", status, 8'h80);
  endtask

  task automatic t_ctl_fields();
    logic [7:0] b;
    ctl(8'h2D); tick();
    chk("R2 drive sel", {6'b0, drive_sel}, 8'h01);
    chk("R2 motor1", {6'b0, motor_on}, 8'h02);
    chk("R2 no release", {7'b0, irq}, 8'h00);
    ctl(8'h08); tick();
    chk("R3 held in reset", status, 8'h00);
    ctl(8'h0C); tick(); tick();
    chk("R3 irq again", {7'b0, irq}, 8'h01);
    put(8'h08, 1'b1);
    get(b); chk("R3 pending after release", b, 8'hC0);
    get(b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_release();
    t_sense_after_reset();
    t_version();
    t_noresult(8'h13, 3, "R5 configure tail");
    t_noresult(8'h03, 2, "R5 specify tail");
    t_recal();
    t_unknown();
    t_bad_access();
    t_ctl_fields();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule